// File: doc/BRIEF.md
# Single-Wire Phase-Following Oscillator

This block is a numerically controlled oscillator for a follower device. It tracks a leader oscillator that runs from an unrelated clock. The two sides share a single wire. The leader raises that wire once each time its 32-bit phase accumulator wraps through zero. The follower samples the wire through a short synchroniser and finds the rising edge. When an edge arrives, it reads its own accumulator value. That value is the phase error, because the leader is at zero at that moment. The follower then retunes its per-clock phase step.

Three behaviours can be selected. The default tracking mode never jumps the phase. It sets the step to the nominal step minus a shifted copy of the signed error, and clamps the result to within one sixteenth of the nominal step. The snap mode clears the accumulator at each edge and accepts the discontinuity that causes. The counting mode measures the clocks between two successive edges and sets the step to the full phase circle divided by that count. A lock flag reports a steady run of small errors. A sine table or other waveform stage can be fed from the phase output.

Top module: `phase_follow_nco`

## Requirements
- R1: While `rst_n` is low, `phase_out`, `inc_out`, `phase_valid` and `locked` are all zero. At the first rising clock after release, `inc_out` takes the value of `nominal_inc`.
- R2: On every clock that is not a snap clear, `phase_out` grows by the current `inc_out`, modulo 2^32.
- R3: `sync_in` passes through two flip-flops and is acted on only at its rising edge. The action happens on the third rising clock at which `sync_in` is sampled high, counting its first sample as the first. A pulse of any width is acted on exactly once.
- R4: With `mode_sel` = 1 (snap), each sync action sets `phase_out` to 0 and sets `inc_out` to `nominal_inc`.
- R5: With `mode_sel` = 0 or 3 (track), a sync action sets `inc_out` = `nominal_inc` − (e >>> `gain_shift`). Here e is `phase_out` read as a signed 32-bit number in the clock cycle just before the action.
- R6: In track mode the new step is clamped to the range [N − (N>>4), min(N + (N>>4), 2^32−1)], where N is `nominal_inc`.
- R7: After the first sync action, in modes 0, 2 and 3, `inc_out` changes only at sync actions. Changes to `nominal_inc` between actions have no effect.
- R8: With `mode_sel` = 2 (count), a sync action sets `inc_out` = floor(2^32 / P), where P is the number of clocks since the previous action. The first action after reset leaves `inc_out` at `nominal_inc`.
- R9: `phase_valid` is low from reset until the first sync action. After that it stays high.
- R10: `locked` rises at the fourth consecutive sync action whose |e| is below `lock_thresh`. Any action with |e| ≥ `lock_thresh` clears `locked` immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Follower clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Zero-crossing pulse from the leader, asynchronous to `clk` |
| mode_sel | input | 2 | 0/3 track, 1 snap, 2 count |
| nominal_inc | input | 32 | Nominal phase step per clock |
| gain_shift | input | 4 | Right-shift applied to the phase error in track mode |
| lock_thresh | input | 32 | Error magnitude below which an action counts toward lock |
| phase_out | output | 32 | Accumulated phase |
| phase_valid | output | 1 | High once the first sync action has occurred |
| locked | output | 1 | Run of small phase errors reached |
| inc_out | output | 32 | Phase step currently in use |

## Verification
A vector table drives track-mode sync actions with different nominal steps, gain shifts and gaps between pulses. Small steps with large shifts check the proportional term without clamping. A zero shift forces the clamp against its lower or upper limit. A step near the top of the range exercises the cap at 2^32−1, and a mode value of 3 confirms it behaves as track mode. Directed tests follow the table. They hold a long pulse in snap mode, to tell a single edge action from a level-triggered one. They space two counting-mode pulses exactly 1000 clocks apart, to check the division against a known count. They change the nominal step between pulses, to show that the active step is held. They vary the threshold so the lock flag both rises and drops.

// File: rtl/psnco_pkg.sv
package psnco_pkg;
   typedef enum logic [1:0] {
      M_TRACK     = 2'd0,
      M_SNAP      = 2'd1,
      M_COUNT     = 2'd2,
      M_TRACK_ALT = 2'd3
   } track_mode_e;
endpackage

// File: rtl/psnco_sync_edge.sv
module psnco_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic pulse
);
   if (STAGES < 2) begin : g_bad_stages
      $error("psnco_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], din};
   end

   assign pulse = chain[STAGES-1] & ~chain[STAGES];

   // R3: one action per pulse, however long the pulse is held
   a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);
endmodule

// File: rtl/psnco_accum.sv
module psnco_accum #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [W-1:0] step,
   output logic [W-1:0] phase
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   phase <= '0;
      else if (clr) phase <= '0;
      else          phase <= phase + step;
   end

   a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> phase == W'($past(phase) + $past(step)));

   a_r4_snap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> phase == '0);
endmodule

// File: rtl/psnco_inc_ctrl.sv
module psnco_inc_ctrl
   import psnco_pkg::*;
#(
   parameter int W        = 32,
   parameter int SHIFT_W  = 4,
   parameter int CLAMP_SH = 4,
   parameter bit HAS_COUNT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               evt,
   input  track_mode_e        mode,
   input  logic [W-1:0]       nominal,
   input  logic [SHIFT_W-1:0] shift,
   input  logic [W-1:0]       err,
   output logic [W-1:0]       inc,
   output logic               seeded
);
   localparam int XW = W + 2;
   localparam logic signed [XW-1:0] CAP = $signed({2'b00, {W{1'b1}}});

   if (CLAMP_SH < 1 || CLAMP_SH >= W) begin : g_bad_clamp
      $error("psnco_inc_ctrl: CLAMP_SH out of range");
   end

   logic signed [XW-1:0] nom_x, span, lo, hi_raw, hi, errx, corr, trial, bounded;
   logic [W-1:0] trk_inc, cnt_inc, cnt;
   logic         have_prev;

   always_comb begin
      nom_x  = $signed({2'b00, nominal});
      span   = $signed({2'b00, nominal >> CLAMP_SH});
      lo     = nom_x - span;
      hi_raw = nom_x + span;
      hi     = (hi_raw > CAP) ? CAP : hi_raw;
      errx   = $signed({{2{err[W-1]}}, err});
      corr   = errx >>> shift;
      trial  = nom_x - corr;
      if (trial < lo)      bounded = lo;
      else if (trial > hi) bounded = hi;
      else                 bounded = trial;
      trk_inc = bounded[W-1:0];
   end

   if (HAS_COUNT) begin : g_count
      localparam logic [W:0] CIRCLE = {1'b1, {W{1'b0}}};
      logic [W:0]   period;
      logic [W-1:0] quo;
      assign period  = {1'b0, cnt} + (W+1)'(1);
      assign quo     = W'(CIRCLE / period);
      assign cnt_inc = (have_prev && period >= (W+1)'(2)) ? quo : nominal;
   end else begin : g_no_count
      assign cnt_inc = nominal;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inc       <= '0;
         seeded    <= 1'b0;
         cnt       <= '0;
         have_prev <= 1'b0;
      end else if (evt) begin
         seeded    <= 1'b1;
         have_prev <= 1'b1;
         cnt       <= '0;
         case (mode)
            M_SNAP:  inc <= nominal;
            M_COUNT: inc <= cnt_inc;
            default: inc <= trk_inc;
         endcase
      end else begin
         if (cnt != '1) cnt <= cnt + W'(1);
         if (!seeded || mode == M_SNAP) inc <= nominal;
      end
   end

   a_r6_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && (mode == M_TRACK || mode == M_TRACK_ALT)) |=>
         ($signed({2'b00, inc}) >= $past(lo) && $signed({2'b00, inc}) <= $past(hi)));

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt && seeded && mode != M_SNAP) |=> $stable(inc));

   a_r9_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      seeded |=> seeded);
endmodule

// File: rtl/psnco_lock.sv
module psnco_lock #(
   parameter int W   = 32,
   parameter int RUN = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         evt,
   input  logic [W-1:0] err,
   input  logic [W-1:0] thresh,
   output logic         locked
);
   localparam int CW = $clog2(RUN + 1);

   if (RUN < 1) begin : g_bad_run
      $error("psnco_lock: RUN must be at least 1");
   end

   logic [CW-1:0] run;
   logic [W-1:0]  mag;
   logic          good;

   assign mag    = err[W-1] ? (~err + W'(1)) : err;
   assign good   = mag < thresh;
   assign locked = (run == CW'(RUN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run <= '0;
      else if (evt) begin
         if (!good)       run <= '0;
         else if (!locked) run <= run + CW'(1);
      end
   end

   a_r10_lock_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> ($past(evt) && $past(good)));

   a_r10_lock_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && !good) |=> !locked);
endmodule

// File: rtl/phase_follow_nco.sv
module phase_follow_nco
   import psnco_pkg::*;
#(
   parameter int PHASE_W     = 32,
   parameter int SHIFT_W     = 4,
   parameter int SYNC_STAGES = 2,
   parameter int LOCK_RUN    = 4,
   parameter bit HAS_COUNT   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sync_in,
   input  logic [1:0]         mode_sel,
   input  logic [PHASE_W-1:0] nominal_inc,
   input  logic [SHIFT_W-1:0] gain_shift,
   input  logic [PHASE_W-1:0] lock_thresh,
   output logic [PHASE_W-1:0] phase_out,
   output logic               phase_valid,
   output logic               locked,
   output logic [PHASE_W-1:0] inc_out
);
   if (PHASE_W < 8 || PHASE_W > 32) begin : g_bad_width
      $error("phase_follow_nco: PHASE_W must lie in 8..32");
   end

   track_mode_e mode;
   logic        evt, clr;

   assign mode = track_mode_e'(mode_sel);
   assign clr  = evt && (mode == M_SNAP);

   psnco_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(sync_in), .pulse(evt));

   psnco_accum #(.W(PHASE_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(clr), .step(inc_out), .phase(phase_out));

   psnco_inc_ctrl #(.W(PHASE_W), .SHIFT_W(SHIFT_W), .CLAMP_SH(4), .HAS_COUNT(HAS_COUNT)) u_inc (
      .clk(clk), .rst_n(rst_n), .evt(evt), .mode(mode), .nominal(nominal_inc),
      .shift(gain_shift), .err(phase_out), .inc(inc_out), .seeded(phase_valid));

   psnco_lock #(.W(PHASE_W), .RUN(LOCK_RUN)) u_lock (
      .clk(clk), .rst_n(rst_n), .evt(evt), .err(phase_out),
      .thresh(lock_thresh), .locked(locked));
endmodule

// File: tb/sim_phase_follow_nco.sv
module sim_phase_follow_nco;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sync_in = 1'b0;
   logic [1:0]  mode_sel = 2'd0;
   logic [31:0] nominal_inc = 32'h0100_0000;
   logic [3:0]  gain_shift = 4'd4;
   logic [31:0] lock_thresh = 32'h0;
   logic [31:0] phase_out, inc_out;
   logic        phase_valid, locked;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   always #4 clk = ~clk;

   phase_follow_nco u0 (
      .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .mode_sel(mode_sel),
      .nominal_inc(nominal_inc), .gain_shift(gain_shift), .lock_thresh(lock_thresh),
      .phase_out(phase_out), .phase_valid(phase_valid), .locked(locked), .inc_out(inc_out));

   localparam int NV = 6;
   localparam logic [1:0]  V_MODE [NV] = '{2'd0, 2'd0, 2'd0, 2'd3, 2'd0, 2'd0};
   localparam logic [31:0] V_NOM  [NV] = '{32'h0100_0000, 32'h0100_0000, 32'h0123_4567,
                                           32'h0200_0000, 32'hFFFF_0000, 32'h0000_0100};
   localparam logic [3:0]  V_SH   [NV] = '{4'd4, 4'd0, 4'd15, 4'd8, 4'd12, 4'd2};
   localparam int          V_GAP  [NV] = '{37, 50, 11, 23, 5, 29};

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] model_trk(input logic [31:0] nom, input logic [31:0] err,
                                             input logic [3:0] sh);
      longint n, e, t, lo, hi;
      n  = longint'({32'b0, nom});
      e  = longint'($signed(err));
      t  = n - (e >>> sh);
      lo = n - (n >>> 4);
      hi = n + (n >>> 4);
      if (hi > 64'sh0000_0000_FFFF_FFFF) hi = 64'sh0000_0000_FFFF_FFFF;
      if (t < lo) t = lo;
      else if (t > hi) t = hi;
      return t[31:0];
   endfunction

   // called at a falling edge; returns at the falling edge after the action edge
   task automatic pulse(output logic [31:0] err);
      sync_in = 1'b1;
      @(negedge clk);
      sync_in = 1'b0;
      @(negedge clk);
      err = phase_out;
      @(negedge clk);
   endtask

   task automatic check_advance(input string req);
      logic [31:0] p0, s0;
      p0 = phase_out;
      s0 = inc_out;
      @(negedge clk);
      chk(phase_out == p0 + s0, req, phase_out, p0 + s0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      logic [31:0] e, held;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(phase_out == 0 && inc_out == 0, "R1 reset phase/inc", {phase_out[15:0], inc_out[15:0]}, 32'd0);
      chk(!phase_valid && !locked, "R1 reset flags", {30'd0, phase_valid, locked}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(inc_out == nominal_inc, "R1 step loads nominal", inc_out, nominal_inc);
      repeat (5) @(negedge clk);
      chk(!phase_valid, "R9 valid low before sync", {31'd0, phase_valid}, 32'd0);
      check_advance("R2 free run");

      // R5/R6 vector table in track mode
      for (int i = 0; i < NV; i++) begin
         mode_sel    = V_MODE[i];
         nominal_inc = V_NOM[i];
         gain_shift  = V_SH[i];
         repeat (V_GAP[i]) @(negedge clk);
         pulse(e);
         chk(inc_out == model_trk(V_NOM[i], e, V_SH[i]), "R5/R6 track step", inc_out,
             model_trk(V_NOM[i], e, V_SH[i]));
         if (i == 0) chk(phase_valid, "R9 valid after first sync", {31'd0, phase_valid}, 32'd1);
         check_advance("R2 after track action");
      end

      // R7: nominal change between actions is ignored
      held = inc_out;
      nominal_inc = 32'h0777_0000;
      repeat (6) @(negedge clk);
      chk(inc_out == held, "R7 step held", inc_out, held);

      // R4 + R3: long pulse in snap mode clears once
      mode_sel = 2'd1;
      nominal_inc = 32'h0010_0000;
      @(negedge clk);
      sync_in = 1'b1;
      repeat (3) @(negedge clk);
      chk(phase_out == 0, "R4 snap clears phase", phase_out, 32'd0);
      chk(inc_out == 32'h0010_0000, "R4 snap step nominal", inc_out, 32'h0010_0000);
      repeat (3) @(negedge clk);
      chk(phase_out == 32'h0030_0000, "R3 single action on long pulse", phase_out, 32'h0030_0000);
      sync_in = 1'b0;
      repeat (4) @(negedge clk);

      // R10: lock drop and rise
      lock_thresh = 32'h0;
      pulse(e);
      chk(!locked, "R10 lock drops on large error", {31'd0, locked}, 32'd0);
      lock_thresh = 32'hFFFF_FFFF;
      for (int k = 0; k < 3; k++) begin
         repeat (4) @(negedge clk);
         pulse(e);
      end
      chk(!locked, "R10 not locked after three", {31'd0, locked}, 32'd0);
      repeat (4) @(negedge clk);
      pulse(e);
      chk(locked, "R10 locked after four", {31'd0, locked}, 32'd1);

      // R8: counting mode, actions 1000 clocks apart
      mode_sel = 2'd2;
      pulse(e);
      repeat (997) @(negedge clk);
      pulse(e);
      chk(inc_out == 32'd4294967, "R8 count step", inc_out, 32'd4294967);
      nominal_inc = 32'h0123_0000;
      repeat (10) @(negedge clk);
      chk(inc_out == 32'd4294967, "R7 count step held", inc_out, 32'd4294967);

      // R8: first action after reset keeps nominal
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      nominal_inc = 32'h0055_0000;
      repeat (20) @(negedge clk);
      pulse(e);
      chk(inc_out == 32'h0055_0000, "R8 first count action nominal", inc_out, 32'h0055_0000);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule